// File: doc/BRIEF.md
# One-Step Timestamp Inserter

This block sits on a byte-wide transmit frame stream and rewrites frames that the client marks for one-step precision time operation. For each such frame it takes the time value present on `time_in` when the first byte arrives and adds a small fixed-point latency trim. It then writes the result big-endian over a time field at a per-frame byte offset. In transparent-clock mode the time input is read as a residence-time correction instead. That correction and the trim are added to the 64-bit correction field already present in the frame. When the client asks for it, the 16-bit UDP checksum at a second per-frame offset is fixed incrementally, so the datagram stays valid without a pass over the whole payload. Every frame leaves the block exactly eight cycles after it enters. This holds whether or not the frame is touched.

All per-frame controls are sampled together with the first byte of a frame: the operation code, the enable, the mode, the trim, the time input, both offsets and the checksum flag. The client must meet these stream rules:
- A frame is driven with `in_valid` high on every cycle from its first byte to its last.
- At least eight idle cycles separate the last byte of one frame from the first byte of the next.
- The time field lies inside the frame.
- The checksum word starts at or after the end of the field, at an offset of the same parity as the field offset.

Top module: `ptp_onestep_ins`

## Requirements
- R1: Every byte, together with its valid and last flags, appears at the output exactly 8 cycles after it is accepted, and while reset is held the output valid is 0.
- R2: A frame whose sampled operation code is not 2'b01 (2'b00 none, 2'b10 two-step, 2'b11 reserved), or whose sampled enable is 0, leaves byte for byte unchanged.
- R3: In normal mode a one-step frame gets 10 bytes written at the time-field offset (byte 0 is the first byte of the frame). Bytes 0..5 carry the seconds, taken from `time_in[79:32]`, and bytes 6..9 carry the nanoseconds, taken from `time_in[31:0]`, both most significant byte first. The nanoseconds are increased by the whole-nanosecond part of the trim, bits [10:3], and the fractional bits [2:0] are dropped. The trim and time are the values seen with the first byte.
- R4: When the nanosecond sum in normal mode reaches 1,000,000,000, that amount is subtracted and the seconds are incremented, wrapping modulo 2^48.
- R5: In transparent-clock mode the 8-byte big-endian field at the offset is replaced by old value + `time_in[63:0]` + trim·2^13, modulo 2^64. The field is in units of 2^-16 ns, and `time_in[63]` must be 0.
- R6: With the checksum flag set on a one-step frame, the big-endian 16-bit word at the checksum offset is rewritten so that the 16-bit ones'-complement checksum over the frame's words, aligned with the field, stays correct, and a result of 0 is sent as 16'hFFFF. With the flag clear, those two bytes are unchanged.
- R7: In a modified frame, every byte outside the time field and the checksum word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| sb_op | input | 2 | Per-frame operation code (2'b01 = one-step) |
| sb_ts_off | input | 16 | Byte offset of the time or correction field |
| sb_ck_off | input | 16 | Byte offset of the UDP checksum word |
| sb_ck_upd | input | 1 | Request checksum fix-up for this frame |
| cfg_onestep_en | input | 1 | Global one-step enable |
| cfg_tc_mode | input | 1 | 1 = transparent-clock correction add |
| cfg_lat_adj | input | 11 | Latency trim, [10:3] ns and [2:0] eighths of a ns |
| time_in | input | 80 | Time value, or correction value in transparent mode |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final byte of a frame |

## Verification
The bench crosses all four operation codes with both enable values. This separates frames that must be rewritten from the three kinds that must pass untouched.

A sweep of the trim over its 11-bit range runs with nanosecond inputs just under one second and with all-ones seconds. It tells the carry-free sums apart from those that must roll into the seconds and wrap.

Transparent-mode frames carry pseudo-random correction fields at shifting offsets, which exercises byte-to-byte carries in the 64-bit add. Each frame arrives with a correct checksum. The checksum written by the block is then compared with one recomputed from scratch over the output frame, which shows that the incremental fix-up matches a full sum, and frames with the flag clear show the word is left alone.

// File: rtl/ptp1s_pkg.sv
`timescale 1ns/1ps
package ptp1s_pkg;
    localparam int BYTE_W  = 8;
    localparam int TS_W    = 80;
    localparam int NS_W    = 32;
    localparam int SEC_W   = TS_W - NS_W;
    localparam int CORR_W  = 64;
    localparam int CORR_FRAC = 16;
    localparam int FL_NORM = 10;
    localparam int FL_TC   = 8;
    localparam int DLY     = 8;
    localparam logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_ONE  = 2'b01,
        OP_TWO  = 2'b10,
        OP_RSV  = 2'b11
    } op_e;

    typedef struct packed {
        logic              vld;
        logic              lst;
        logic [BYTE_W-1:0] dat;
    } beat_t;

    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'b0, s[16]};
    endfunction
endpackage

// File: rtl/ptp1s_delay.sv
`timescale 1ns/1ps
module ptp1s_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] tap_last,
    output logic [W-1:0] tap_prev
);
    logic [W-1:0] stg_q [DEPTH];
    logic [W-1:0] stg_d [DEPTH];

    always_comb begin
        stg_d[0] = d_in;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d[i];
        end
    end

    assign tap_last = stg_q[DEPTH-1];
    assign tap_prev = stg_q[DEPTH-2];
endmodule

// File: rtl/ptp1s_csum.sv
`timescale 1ns/1ps
module ptp1s_csum
    import ptp1s_pkg::*;
#(
    parameter int FW = 80
) (
    input  logic [FW-1:0] old_f,
    input  logic [FW-1:0] new_f,
    input  logic [15:0]   hc_in,
    output logic [15:0]   hc_out
);
    localparam int NW = FW / 16;

    logic [15:0] acc;
    logic [15:0] res;

    always_comb begin
        acc = ~hc_in;
        for (int k = 0; k < NW; k++) begin
            acc = oc_add(acc, ~old_f[k*16 +: 16]);
            acc = oc_add(acc, new_f[k*16 +: 16]);
        end
        res    = ~acc;
        hc_out = (res == 16'h0000) ? 16'hFFFF : res;
    end
endmodule

// File: rtl/ptp_onestep_ins.sv
`timescale 1ns/1ps
module ptp_onestep_ins
    import ptp1s_pkg::*;
#(
    parameter int OFF_W    = 16,
    parameter int ADJ_W    = 11,
    parameter int ADJ_FRAC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [1:0]        sb_op,
    input  logic [OFF_W-1:0]  sb_ts_off,
    input  logic [OFF_W-1:0]  sb_ck_off,
    input  logic              sb_ck_upd,
    input  logic              cfg_onestep_en,
    input  logic              cfg_tc_mode,
    input  logic [ADJ_W-1:0]  cfg_lat_adj,
    input  logic [TS_W-1:0]   time_in,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last
);
    localparam int CORR_SHIFT = CORR_FRAC - ADJ_FRAC;
    localparam int PW         = OFF_W + 1;

    typedef struct packed {
        logic              in_first;
        logic [OFF_W-1:0]  in_pos;
        logic              act;
        logic              tc;
        logic              upd;
        logic [OFF_W-1:0]  toff;
        logic [OFF_W-1:0]  coff;
        logic [ADJ_W-1:0]  adj;
        logic [TS_W-1:0]   tmr;
        logic [TS_W-1:0]   oldf;
        logic [TS_W-1:0]   newf;
        logic [OFF_W-1:0]  out_pos;
        logic [7:0]        ck_lo;
    } st_t;

    st_t st_d, st_q;

    beat_t beat_in, tap_q, prev_q;
    logic [$bits(beat_t)-1:0] tap_raw, prev_raw;

    logic              sop;
    logic [NS_W:0]     ns_sum;
    logic [SEC_W-1:0]  sec_nx;
    logic [OFF_W-1:0]  in_p;
    logic [PW-1:0]     in_fl, o_fl;
    logic              in_fld, o_fld;
    logic [PW-1:0]     o_idx;
    logic [6:0]        o_sh;
    logic [TS_W-1:0]   o_shifted;
    logic [15:0]       hc_new;

    assign beat_in = '{vld: in_valid, lst: in_last, dat: in_data};

    ptp1s_delay #(.W($bits(beat_t)), .DEPTH(DLY)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_in     (beat_in),
        .tap_last (tap_raw),
        .tap_prev (prev_raw)
    );

    assign tap_q  = beat_t'(tap_raw);
    assign prev_q = beat_t'(prev_raw);

    ptp1s_csum #(.FW(TS_W)) u_csum (
        .old_f  (st_q.oldf),
        .new_f  (st_q.newf),
        .hc_in  ({tap_q.dat, prev_q.dat}),
        .hc_out (hc_new)
    );

    always_comb begin
        st_d   = st_q;
        sop    = in_valid && st_q.in_first;
        ns_sum = '0;
        sec_nx = '0;

        // ---- input side: sample per-frame context on the first byte ----
        if (sop) begin
            st_d.act  = cfg_onestep_en && (op_e'(sb_op) == OP_ONE);
            st_d.tc   = cfg_tc_mode;
            st_d.upd  = sb_ck_upd;
            st_d.toff = sb_ts_off;
            st_d.coff = sb_ck_off;
            st_d.adj  = cfg_lat_adj;
            st_d.tmr  = time_in;
            st_d.oldf = '0;
            ns_sum = {1'b0, time_in[NS_W-1:0]}
                   + (NS_W+1)'(cfg_lat_adj[ADJ_W-1:ADJ_FRAC]);
            sec_nx = time_in[TS_W-1:NS_W];
            if (ns_sum >= {1'b0, NS_PER_SEC}) begin
                ns_sum = ns_sum - {1'b0, NS_PER_SEC};
                sec_nx = sec_nx + SEC_W'(1);
            end
            st_d.newf = cfg_tc_mode ? '0 : {sec_nx, ns_sum[NS_W-1:0]};
        end

        in_p   = sop ? '0 : st_q.in_pos;
        in_fl  = st_d.tc ? PW'(FL_TC) : PW'(FL_NORM);
        in_fld = in_valid && ({1'b0, in_p} >= {1'b0, st_d.toff})
                          && ({1'b0, in_p} <  {1'b0, st_d.toff} + in_fl);
        if (in_fld) begin
            st_d.oldf = {st_d.oldf[TS_W-BYTE_W-1:0], in_data};
        end
        if (in_fld && st_d.tc && ({1'b0, in_p} == {1'b0, st_d.toff} + PW'(FL_TC - 1))) begin
            st_d.newf = {{(TS_W-CORR_W){1'b0}},
                         st_d.oldf[CORR_W-1:0] + st_d.tmr[CORR_W-1:0]
                         + (CORR_W'(st_d.adj) << CORR_SHIFT)};
        end
        if (in_valid) begin
            st_d.in_pos   = in_p + OFF_W'(1);
            st_d.in_first = in_last;
        end

        // ---- output side: patch bytes leaving the delay line ----
        out_valid = tap_q.vld;
        out_last  = tap_q.lst;
        out_data  = tap_q.dat;
        o_fl      = st_q.tc ? PW'(FL_TC) : PW'(FL_NORM);
        o_idx     = {1'b0, st_q.out_pos} - {1'b0, st_q.toff};
        o_fld     = st_q.act && tap_q.vld
                    && ({1'b0, st_q.out_pos} >= {1'b0, st_q.toff})
                    && ({1'b0, st_q.out_pos} <  {1'b0, st_q.toff} + o_fl);
        o_sh      = 7'((o_fl[3:0] - 4'd1 - o_idx[3:0])) << 3;
        o_shifted = st_q.newf >> o_sh;
        if (tap_q.vld) begin
            if (o_fld) begin
                out_data = o_shifted[7:0];
            end else if (st_q.act && st_q.upd && st_q.out_pos == st_q.coff) begin
                out_data   = hc_new[15:8];
                st_d.ck_lo = hc_new[7:0];
            end else if (st_q.act && st_q.upd && st_q.out_pos == st_q.coff + OFF_W'(1)) begin
                out_data = st_q.ck_lo;
            end
            st_d.out_pos = tap_q.lst ? '0 : st_q.out_pos + OFF_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.in_first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R1

    AST_NS_BELOW_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !st_q.tc && st_q.tmr[NS_W-1:0] < NS_PER_SEC)
        |-> (st_q.newf[NS_W-1:0] < NS_PER_SEC)); // R4

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && !st_q.tc)
        |-> (st_q.newf[TS_W-1:NS_W] == st_q.tmr[TS_W-1:NS_W]
          || st_q.newf[TS_W-1:NS_W] == st_q.tmr[TS_W-1:NS_W] + SEC_W'(1))); // R4

    AST_TC_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (sop && cfg_tc_mode && cfg_onestep_en && sb_op == OP_ONE)
        |-> !time_in[CORR_W-1]); // R5

    AST_CK_AFTER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sop && cfg_onestep_en && sb_op == OP_ONE && sb_ck_upd)
        |-> ({1'b0, sb_ck_off} >= {1'b0, sb_ts_off}
             + (cfg_tc_mode ? PW'(FL_TC) : PW'(FL_NORM)))); // R6
endmodule

// File: tb/ptp_onestep_ins_bench.sv
`timescale 1ns/1ps
module ptp_onestep_ins_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic [1:0]  sb_op = '0;
    logic [15:0] sb_ts_off = '0;
    logic [15:0] sb_ck_off = '0;
    logic        sb_ck_upd = 1'b0;
    logic        cfg_onestep_en = 1'b0;
    logic        cfg_tc_mode = 1'b0;
    logic [10:0] cfg_lat_adj = '0;
    logic [79:0] time_in = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;

    always #2 clk = ~clk;

    ptp_onestep_ins u_ptp_onestep_ins (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .sb_op(sb_op), .sb_ts_off(sb_ts_off),
        .sb_ck_off(sb_ck_off), .sb_ck_upd(sb_ck_upd),
        .cfg_onestep_en(cfg_onestep_en), .cfg_tc_mode(cfg_tc_mode),
        .cfg_lat_adj(cfg_lat_adj), .time_in(time_in),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] frm  [64];
    logic [7:0] expv [64];
    logic [7:0] got  [64];
    logic       glast[64];
    int gcnt   = 0;
    int gfirst = -1;
    int in_cyc = 0;
    logic [31:0] seed = 32'h1234_5678;

    always @(negedge clk) begin
        if (out_valid) begin
            if (gcnt == 0) gfirst = cyc;
            if (gcnt < 64) begin
                got[gcnt]   = out_data;
                glast[gcnt] = out_last;
            end
            gcnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [15:0] ck_of(input logic [7:0] a [64], input int n, input int ck);
        logic [31:0] s;
        logic [15:0] r;
        s = 0;
        for (int k = 0; k < n / 2; k++) begin
            if (2 * k != ck) s = s + {16'h0, a[2*k], a[2*k+1]};
        end
        while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
        r = ~s[15:0];
        if (r == 16'h0000) r = 16'hFFFF;
        return r;
    endfunction

    task automatic run_frame(input int n, input logic [1:0] op, input bit en,
                             input bit tc, input bit upd, input int toff,
                             input int coff, input logic [10:0] adj,
                             input logic [79:0] tmr, input string tag);
        logic [15:0] ck;
        logic [63:0] oldc, newc;
        logic [32:0] ns;
        logic [47:0] sec;
        logic [79:0] val;
        int fl;
        bit modded;
        bit ok;
        int bad;
        for (int i = 0; i < n; i++) frm[i] = rnd()[15:8];
        ck = ck_of(frm, n, coff);
        frm[coff] = ck[15:8];
        frm[coff+1] = ck[7:0];
        expv = frm;
        fl = tc ? 8 : 10;
        modded = en && (op == 2'b01);
        if (modded) begin
            if (tc) begin
                oldc = '0;
                for (int i = 0; i < 8; i++) oldc = {oldc[55:0], frm[toff+i]};
                newc = oldc + tmr[63:0] + ({53'h0, adj} << 13);
                for (int i = 0; i < 8; i++) expv[toff+i] = newc[8*(7-i) +: 8];
            end else begin
                ns  = {1'b0, tmr[31:0]} + {25'h0, adj[10:3]};
                sec = tmr[79:32];
                if (ns >= 33'd1000000000) begin
                    ns  = ns - 33'd1000000000;
                    sec = sec + 48'd1;
                end
                val = {sec, ns[31:0]};
                for (int i = 0; i < 10; i++) expv[toff+i] = val[8*(9-i) +: 8];
            end
            if (upd) begin
                ck = ck_of(expv, n, coff);
                expv[coff] = ck[15:8];
                expv[coff+1] = ck[7:0];
            end
        end
        gcnt = 0;
        gfirst = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = frm[i];
            in_last  = (i == n - 1);
            if (i == 0) begin
                in_cyc = cyc;
                sb_op = op; sb_ts_off = 16'(toff); sb_ck_off = 16'(coff);
                sb_ck_upd = upd; cfg_onestep_en = en; cfg_tc_mode = tc;
                cfg_lat_adj = adj; time_in = tmr;
            end else begin
                sb_op = ~op; sb_ck_upd = ~upd; cfg_onestep_en = ~en;
                cfg_lat_adj = ~adj; time_in = ~tmr; sb_ts_off = 16'(toff + 2);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (12) @(negedge clk);
        // R1: fixed latency and frame length
        check(gfirst - in_cyc == 8, "R1", "latency", longint'(gfirst - in_cyc), 8);
        check(gcnt == n && glast[n-1] == 1'b1, "R1", "byte count", gcnt, n);
        ok = 1; bad = 0;
        for (int i = 0; i < n; i++) begin
            if (ok && got[i] != expv[i]) begin ok = 0; bad = i; end
        end
        check(ok, tag, $sformatf("byte %0d", bad), got[bad], expv[bad]);
        // R7: bytes outside field and checksum untouched
        ok = 1; bad = 0;
        for (int i = 0; i < n; i++) begin
            if (!(modded && ((i >= toff && i < toff + fl) || i == coff || i == coff + 1))) begin
                if (ok && got[i] != frm[i]) begin ok = 0; bad = i; end
            end
        end
        check(ok, "R7", $sformatf("untouched byte %0d", bad), got[bad], frm[bad]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", "reset valid", out_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 / R3: operation code and enable cross
        for (int op = 0; op < 4; op++) begin
            for (int en = 0; en < 2; en++) begin
                run_frame(32, 2'(op), 1'(en), 1'b0, 1'b1, 6, 28, 11'h155,
                          {48'h0000_1234_5678, 32'd500_000_000},
                          (en == 1 && op == 1) ? "R3" : "R2");
                run_frame(32, 2'(op), 1'(en), 1'b1, 1'b1, 4, 20, 11'h2A3,
                          {16'h0, 64'h0000_0123_4567_89AB},
                          (en == 1 && op == 1) ? "R5" : "R2");
            end
        end

        // R4: trim sweep around the second boundary, with seconds wrap
        for (int a = 0; a < 2048; a += 13) begin
            run_frame(32, 2'b01, 1'b1, 1'b0, 1'(a % 2), (a % 8) * 2, 30 - (a % 3) * 2,
                      11'(a),
                      {((a % 3) == 0) ? 48'hFFFF_FFFF_FFFF : 48'(a * 1000),
                       32'd999_999_800 + 32'((a % 5) * 40)},
                      "R4");
        end
        run_frame(32, 2'b01, 1'b1, 1'b0, 1'b1, 0, 10, 11'h7FF,
                  {48'h0000_0000_0007, 32'd12}, "R3");

        // R5: transparent-clock correction add with random fields
        for (int k = 0; k < 120; k++) begin
            run_frame(32, 2'b01, 1'b1, 1'b1, 1'(k % 2), (k % 10) * 2,
                      (k % 10) * 2 + 8 + (k % 3) * 2, 11'(rnd()),
                      {16'(rnd()), 1'b0, 31'(rnd()), rnd()}, "R5");
        end

        // R6: checksum on and off in both modes
        for (int k = 0; k < 40; k++) begin
            run_frame(40, 2'b01, 1'b1, 1'(k % 2), (k % 4) != 3, 2 * (k % 6),
                      2 * (k % 6) + 10 + 2 * (k % 5), 11'(rnd()),
                      {16'(rnd()), 1'b0, 31'(rnd()), 32'(rnd() % 32'd999_000_000)}, "R6");
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule